// File: doc/BRIEF.md
# FSK Period Classifier and Run-Length Bit Slicer

The block takes a stream of 8-bit envelope samples from a two-tone frequency-shift-keyed carrier and turns it into a raw stream of half-bit symbols. It compares each accepted sample with a fixed level to get a binary waveform and marks each low-to-high change as a rising edge. The number of samples between two rising edges is one carrier period. A short period is labelled as the fast tone (nominally 8 samples) and a long period as the slow tone (nominally 10 samples).

Periods with the same label are grouped into runs. When a run ends, its length is converted into a symbol count by rounded division: six fast periods or five slow periods make one symbol. The occasional extra spacer period is lost in the rounding. A run worth one to four symbols is emitted as that many identical bits, one per clock cycle. A fast run yields ones and a slow run yields zeros, so a frame marker appears as three ones followed by three zeros. A Manchester decoder placed downstream receives the bit stream.

Top module: `fsk_run_slicer`

## Requirements
- R1: A sample with value 127 or more is a high level. A sample of 126 or less is a low level.
- R2: No period is measured and no bit is produced until the first rising edge after reset has been accepted. That first edge only starts the count.
- R3: A period is the number of accepted samples from one rising-edge sample up to, but not including, the next rising-edge sample. A period below 9 is fast and emits bit value 1. A period of 9 or more is slow and emits bit value 0. Measured periods of 7 and 8 count as fast, and periods of 9 to 11 count as slow.
- R4: A fast run of n periods is worth floor((n+1)/6) bits.
- R5: A slow run of n periods is worth floor((n+1)/5) bits.
- R6: A run worth 1, 2, 3 or 4 bits emits exactly that many copies of its bit, one per cycle with out_valid high. A run worth 0 bits or more than 4 bits emits nothing.
- R7: A run ends only at the rising edge that closes a period of the other class, or at a break. Its first bit is presented in the cycle after that edge sample is accepted.
- R8: The period count saturates at 255. A rising edge that closes a saturated period is a break: it ends the current run (which is emitted per R6), the saturated period joins no run, and the following periods start a fresh run.
- R9: A sample offered with in_valid low has no effect on level, edge detection, counts or runs.
- R10: After reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe, at most one sample per cycle |
| in_sample | input | 8 | Envelope sample, unsigned |
| out_valid | output | 1 | A symbol bit is present on out_bit |
| out_bit | output | 1 | Symbol bit: 1 for a fast run, 0 for a slow run |

## Verification
Internal state shows up at the ports only when a run ends, so an error can stay hidden for a whole run. A miscounted period or a wrong class appears as a missing bit, an extra bit or a flipped bit when the run closes. That happens at the next class change or break, often dozens of samples after the fault. A faulty edge detector or a fault in the sync flag shifts every later run boundary. The scoreboard therefore compares the whole ordered bit stream against lengths chosen on both sides of each rounding step. A run that is mistakenly carried across a break is caught by a case where two runs that each round to nothing would produce a bit if they were merged.

// File: rtl/fsk_run_slicer.sv
module fsk_run_slicer #(
  parameter int SW       = 8,
  parameter int THRESH   = 127,
  parameter int SPLIT    = 9,
  parameter int CNT_MAX  = 255,
  parameter int FAST_DIV = 6,
  parameter int SLOW_DIV = 5,
  parameter int MAX_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_sample,
  output logic          out_valid,
  output logic          out_bit
);
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int PW = $clog2(MAX_BITS + 1);

  logic          lvl, prev_lvl, synced, rise, period_done, brk, cls_now;
  logic [CW-1:0] cnt, run_len;
  logic          run_act, run_cls;
  logic [PW-1:0] pend;
  logic          pend_bit;
  logic [CW:0]   len_p1, nbits;
  logic          flush, load;

  assign lvl         = in_sample >= SW'(THRESH);
  assign rise        = in_valid && lvl && !prev_lvl;
  assign period_done = rise && synced;
  assign brk         = cnt == CW'(CNT_MAX);
  assign cls_now     = cnt < CW'(SPLIT);
  assign flush       = period_done && run_act && (brk || cls_now != run_cls);
  assign len_p1      = {1'b0, run_len} + 1'b1;
  assign nbits       = run_cls ? len_p1 / (CW+1)'(FAST_DIV) : len_p1 / (CW+1)'(SLOW_DIV);
  assign load        = flush && nbits != '0 && nbits <= (CW+1)'(MAX_BITS);
  assign out_valid   = pend != '0;
  assign out_bit     = pend_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_lvl <= 1'b1;
      synced   <= 1'b0;
      cnt      <= '0;
    end else if (in_valid) begin
      prev_lvl <= lvl;
      if (rise) begin
        synced <= 1'b1;
        cnt    <= CW'(1);
      end else if (synced && !brk) begin
        cnt <= cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_act <= 1'b0;
      run_cls <= 1'b0;
      run_len <= '0;
    end else if (period_done) begin
      if (brk) begin
        run_act <= 1'b0;
      end else if (run_act && cls_now == run_cls) begin
        if (run_len != CW'(CNT_MAX)) run_len <= run_len + 1'b1;
      end else begin
        run_act <= 1'b1;
        run_cls <= cls_now;
        run_len <= CW'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend     <= '0;
      pend_bit <= 1'b0;
    end else if (load) begin
      pend     <= nbits[PW-1:0];
      pend_bit <= run_cls;
    end else if (pend != '0) begin
      pend <= pend - 1'b1;
    end

  a_r6_burst_limit: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(MAX_BITS));
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> pend == '0);
  a_r6_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend > PW'(1)) |=> (out_valid && $stable(out_bit)));
  a_r2_silent_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (!run_act && !out_valid));
  a_r8_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rise && brk) |=> brk);
  a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(cnt) && $stable(prev_lvl) && $stable(run_len)));
endmodule

// File: tb/test_fsk_run_slicer.sv
module test_fsk_run_slicer;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, out_valid, out_bit;
  logic [7:0] in_sample = 8'd0;
  logic [7:0] hi = 8'd200, lo = 8'd30;
  logic jam = 1'b0;
  int checks = 0, errors = 0;
  logic exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  fsk_run_slicer i_fsk_run_slicer (.clk, .rst_n, .in_valid, .in_sample, .out_valid, .out_bit);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic b, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(b);
      tag_q.push_back(tag);
    end
  endtask

  task automatic send(input logic [7:0] s);
    @(posedge clk); #1;
    in_valid = 1'b1; in_sample = s;
    if (jam) begin
      @(posedge clk); #1;
      in_valid = 1'b0; in_sample = (s == hi) ? lo : hi;
    end
  endtask

  task automatic period(input int p);
    for (int i = 0; i < p; i++) send(i < p / 2 ? hi : lo);
  endtask

  task automatic run(input int p, input int n);
    for (int i = 0; i < n; i++) period(p);
  endtask

  task automatic finish;
    send(hi);
    for (int i = 0; i < 300; i++) send(lo);
  endtask

  always @(negedge clk)
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected bit", int'(out_bit), -1);
      end else begin
        logic e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_bit === e, t, int'(out_bit), int'(e));
      end
    end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R10 reset", int'(out_valid), 0);
    // R2: levels without a rising edge, then the first edge only syncs
    for (int i = 0; i < 20; i++) send(hi);
    for (int i = 0; i < 5; i++) send(lo);
    // R4 R5 R7: one fast bit, one slow bit
    push(1'b1, 1, "R4 fast run of 6");
    push(1'b0, 1, "R5 slow run of 5");
    run(8, 6);
    period(10);
    send(hi);
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b1, "R7 bit the cycle after closing edge", int'(out_valid), 1);
    for (int i = 0; i < 4; i++) send(hi);
    for (int i = 0; i < 5; i++) send(lo);
    run(10, 3);
    finish;
    // R4 R5: two bits each
    push(1'b1, 2, "R4 fast run of 12");
    push(1'b0, 2, "R5 slow run of 10");
    run(8, 12); run(10, 10); finish;
    // R6: frame marker, three bits each
    push(1'b1, 3, "R6 fast run of 17");
    push(1'b0, 3, "R6 slow run of 15");
    run(8, 17); run(10, 15); finish;
    // R6: four bits each
    push(1'b1, 4, "R6 fast run of 23");
    push(1'b0, 4, "R6 slow run of 19");
    run(8, 23); run(10, 19); finish;
    // R3: fuzzy periods 7/8 fast, 9..11 slow
    push(1'b1, 1, "R3 fast periods 7 and 8");
    push(1'b0, 1, "R3 slow periods 9 to 11");
    period(7); period(8); period(7); period(8); period(8); period(7);
    period(9); period(11); period(10); period(9); period(11);
    finish;
    // R6: runs worth 0 and 6 bits emit nothing
    push(1'b0, 1, "R6 slow run after zero-bit fast run");
    push(1'b0, 1, "R6 slow run after six-bit fast run");
    run(8, 4); run(10, 5); run(8, 35); run(10, 5); finish;
    // R1: threshold at 127 / 126
    hi = 8'd127; lo = 8'd126;
    push(1'b1, 1, "R1 fast run at threshold");
    push(1'b0, 1, "R1 slow run at threshold");
    run(8, 6); run(10, 5); finish;
    hi = 8'd200; lo = 8'd30;
    // R9: inverted samples with in_valid low between every valid one
    jam = 1'b1;
    push(1'b1, 1, "R9 fast run with invalid samples");
    push(1'b0, 1, "R9 slow run with invalid samples");
    run(8, 6); run(10, 5); finish;
    jam = 1'b0;
    // R8: break splits two 3-period fast runs (merged would give a bit)
    push(1'b0, 1, "R8 slow run after break-split fast runs");
    run(8, 3); finish; run(8, 3); run(10, 5); finish;
    send(hi); send(lo);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R7 all expected bits seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule